// File: doc/BRIEF.md
# Dual-Port Interrupt Mailbox

This block lets a host processor and a DSP signal each other through a shared set of registers. Each processor has its own simple register port (byte address, write enable, write data, combinational read data). Both ports see the same register map and may read or write any register in it. There are two directions. The inbound direction raises an interrupt toward the DSP and the outbound direction raises an interrupt toward the host. Each direction holds a 5-bit command register, and its interrupt stays high for as long as any command bit is set.

A sender raises a channel with a read-modify-write of the command register. A command write stores the written value as it is. The receiver acknowledges by writing ones to that direction's clear register, which drops only the command bits at the one positions. A layout parameter picks one of two register maps. The extended map places five 32-bit scratch message registers next to each command register. The compact map packs the four command and clear registers together and has no message storage.

Top module: `mbx_top`

## Requirements
- R1: Command registers are 5 bits wide. Bits 31:5 always read as zero, and written values in those bits are dropped.
- R2: `dsp_irq` is high exactly while the inbound command register is non-zero, and `host_irq` is high exactly while the outbound command register is non-zero. Each becomes visible on the clock edge that updates the register.
- R3: A write to a clear register clears the command bits where the written value is 1 and leaves every other command bit unchanged.
- R4: A write to a command register stores the written value directly, so a bit written as 0 is cleared.
- R5: Clear registers read as zero.
- R6: If a command write and a clear write reach the same direction in the same cycle, the command register takes the written command value.
- R7: When both ports write the same command or message register in the same cycle, the DSP port's value is stored. When both ports write the same clear register in the same cycle, the union of their masks is cleared.
- R8: The extended layout (EXTENDED=1) uses these byte offsets: 0x00 inbound command, 0x04 inbound clear, 0x08/0x0C/0x10/0x14/0x18 inbound messages 0..4, 0x1C outbound command, 0x20 outbound clear, 0x24/0x28/0x2C/0x30/0x34 outbound messages 0..4.
- R9: Message registers are 32-bit read/write storage shared by both ports. Writing them has no effect on either interrupt.
- R10: The compact layout (EXTENDED=0) uses these byte offsets: 0x00 inbound command, 0x04 outbound command, 0x08 inbound clear, 0x0C outbound clear. Every other offset reads zero and ignores writes.
- R11: Reset clears all command and message registers and drives both interrupts low. Offsets that are unmapped or not word-aligned read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dsp_addr | input | ADDR_W | DSP port byte address |
| dsp_we | input | 1 | DSP port write enable |
| dsp_wdata | input | 32 | DSP port write data |
| dsp_rdata | output | 32 | DSP port read data (combinational) |
| host_addr | input | ADDR_W | Host port byte address |
| host_we | input | 1 | Host port write enable |
| host_wdata | input | 32 | Host port write data |
| host_rdata | output | 32 | Host port read data (combinational) |
| dsp_irq | output | 1 | Interrupt to the DSP, driven by the inbound command register |
| host_irq | output | 1 | Interrupt to the host, driven by the outbound command register |

## Verification
The bench builds two instances side by side. The first uses EXTENDED=1 and exercises the ten message registers, the offsets that follow them, and the priority rules for message writes that collide. The second uses EXTENDED=0, which checks the packed command and clear offsets and confirms that the message region has gone away: those offsets read zero and ignore writes. Both instances use ADDR_W=8, which leaves addresses past the end of the map and misaligned addresses available for the unmapped-access checks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 5;
  localparam int MSG_N  = 5;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN_CMD,
    SEL_IN_CLR,
    SEL_OUT_CMD,
    SEL_OUT_CLR,
    SEL_IN_MSG,
    SEL_OUT_MSG
  } kind_t;

  typedef struct packed {
    kind_t            kind;
    logic [IDX_W-1:0] idx;
  } sel_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W   = 8,
  parameter bit EXTENDED = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::sel_t     sel
);
  import mbx_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_IN_MSG  = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_OUT_CMD = WORD_W'(2 + MSG_N);
  localparam logic [WORD_W-1:0] W_OUT_CLR = WORD_W'(3 + MSG_N);
  localparam logic [WORD_W-1:0] W_OUT_MSG = WORD_W'(4 + MSG_N);
  localparam logic [WORD_W-1:0] W_END     = WORD_W'(4 + 2 * MSG_N);

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  generate
    if (EXTENDED) begin : g_ext
      always_comb begin
        sel.kind = SEL_NONE;
        sel.idx  = '0;
        if (aligned) begin
          if (word == '0)                sel.kind = SEL_IN_CMD;
          else if (word == WORD_W'(1))   sel.kind = SEL_IN_CLR;
          else if (word < W_OUT_CMD) begin
            sel.kind = SEL_IN_MSG;
            sel.idx  = IDX_W'(word - W_IN_MSG);
          end
          else if (word == W_OUT_CMD)    sel.kind = SEL_OUT_CMD;
          else if (word == W_OUT_CLR)    sel.kind = SEL_OUT_CLR;
          else if (word < W_END) begin
            sel.kind = SEL_OUT_MSG;
            sel.idx  = IDX_W'(word - W_OUT_MSG);
          end
        end
      end
    end else begin : g_cmp
      always_comb begin
        sel.kind = SEL_NONE;
        sel.idx  = '0;
        if (aligned) begin
          unique case (word)
            WORD_W'(0): sel.kind = SEL_IN_CMD;
            WORD_W'(1): sel.kind = SEL_OUT_CMD;
            WORD_W'(2): sel.kind = SEL_IN_CLR;
            WORD_W'(3): sel.kind = SEL_OUT_CLR;
            default:    sel.kind = SEL_NONE;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mbx_cmd_dir.sv
module mbx_cmd_dir #(
  parameter int CMD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_wr,
  input  logic [CMD_W-1:0] a_data,
  input  logic             b_wr,
  input  logic [CMD_W-1:0] b_data,
  input  logic             a_clr,
  input  logic [CMD_W-1:0] a_mask,
  input  logic             b_clr,
  input  logic [CMD_W-1:0] b_mask,
  output logic [CMD_W-1:0] cmd,
  output logic             irq
);
  logic [CMD_W-1:0] cmd_q, cmd_d, clr_mask;
  logic             cmd_en;

  always_comb begin
    clr_mask = (a_clr ? a_mask : '0) | (b_clr ? b_mask : '0);
    cmd_en   = a_wr | b_wr | a_clr | b_clr;
    if (a_wr)      cmd_d = a_data;
    else if (b_wr) cmd_d = b_data;
    else           cmd_d = cmd_q & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assign cmd = cmd_q;
  assign irq = |cmd_q;

  a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_wr && !b_wr) |=> cmd == ($past(cmd) & ~($past(a_clr ? a_mask : '0) | $past(b_clr ? b_mask : '0))));

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr || b_wr) |=> cmd == $past(a_wr ? a_data : b_data));

  a_r2_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !a_wr && !b_wr && !a_clr && !b_clr) |=> irq);
endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank #(
  parameter int DATA_W = 32,
  parameter int MSG_N  = 5,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_sel,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(MSG_N - 1);

  logic [DATA_W-1:0] mem_q [MSG_N];

  generate
    for (genvar i = 0; i < MSG_N; i++) begin : g_word
      logic              a_hit, b_hit, en;
      logic [DATA_W-1:0] d;

      always_comb begin
        a_hit = a_sel && a_we && (a_idx == IDX_W'(i));
        b_hit = b_sel && b_we && (b_idx == IDX_W'(i));
        en    = a_hit | b_hit;
        d     = a_hit ? a_wdata : b_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mem_q[i] <= '0;
        else if (en) mem_q[i] <= d;
      end
    end
  endgenerate

  always_comb begin
    a_rdata = (a_sel && a_idx <= LAST) ? mem_q[a_idx] : '0;
    b_rdata = (b_sel && b_idx <= LAST) ? mem_q[b_idx] : '0;
  end
endmodule

// File: rtl/mbx_top.sv
module mbx_top #(
  parameter int ADDR_W   = 8,
  parameter bit EXTENDED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dsp_addr,
  input  logic              dsp_we,
  input  logic [31:0]       dsp_wdata,
  output logic [31:0]       dsp_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              dsp_irq,
  output logic              host_irq
);
  import mbx_pkg::*;

  logic              rst_s_n;
  sel_t              d_sel, h_sel;
  logic [CMD_W-1:0]  in_cmd, out_cmd;
  logic [DATA_W-1:0] d_in_msg, h_in_msg, d_out_msg, h_out_msg;

  mbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n));

  mbx_decode #(.ADDR_W(ADDR_W), .EXTENDED(EXTENDED)) u_dec_dsp  (.addr(dsp_addr),  .sel(d_sel));
  mbx_decode #(.ADDR_W(ADDR_W), .EXTENDED(EXTENDED)) u_dec_host (.addr(host_addr), .sel(h_sel));

  mbx_cmd_dir #(.CMD_W(CMD_W)) u_in (
    .clk(clk), .rst_n(rst_s_n),
    .a_wr(dsp_we && d_sel.kind == SEL_IN_CMD),  .a_data(dsp_wdata[CMD_W-1:0]),
    .b_wr(host_we && h_sel.kind == SEL_IN_CMD), .b_data(host_wdata[CMD_W-1:0]),
    .a_clr(dsp_we && d_sel.kind == SEL_IN_CLR),  .a_mask(dsp_wdata[CMD_W-1:0]),
    .b_clr(host_we && h_sel.kind == SEL_IN_CLR), .b_mask(host_wdata[CMD_W-1:0]),
    .cmd(in_cmd), .irq(dsp_irq)
  );

  mbx_cmd_dir #(.CMD_W(CMD_W)) u_out (
    .clk(clk), .rst_n(rst_s_n),
    .a_wr(dsp_we && d_sel.kind == SEL_OUT_CMD),  .a_data(dsp_wdata[CMD_W-1:0]),
    .b_wr(host_we && h_sel.kind == SEL_OUT_CMD), .b_data(host_wdata[CMD_W-1:0]),
    .a_clr(dsp_we && d_sel.kind == SEL_OUT_CLR),  .a_mask(dsp_wdata[CMD_W-1:0]),
    .b_clr(host_we && h_sel.kind == SEL_OUT_CLR), .b_mask(host_wdata[CMD_W-1:0]),
    .cmd(out_cmd), .irq(host_irq)
  );

  generate
    if (EXTENDED) begin : g_msg
      mbx_msg_bank #(.DATA_W(DATA_W), .MSG_N(MSG_N), .IDX_W(IDX_W)) u_in_msg (
        .clk(clk), .rst_n(rst_s_n),
        .a_sel(d_sel.kind == SEL_IN_MSG), .a_we(dsp_we),  .a_idx(d_sel.idx), .a_wdata(dsp_wdata),
        .b_sel(h_sel.kind == SEL_IN_MSG), .b_we(host_we), .b_idx(h_sel.idx), .b_wdata(host_wdata),
        .a_rdata(d_in_msg), .b_rdata(h_in_msg)
      );
      mbx_msg_bank #(.DATA_W(DATA_W), .MSG_N(MSG_N), .IDX_W(IDX_W)) u_out_msg (
        .clk(clk), .rst_n(rst_s_n),
        .a_sel(d_sel.kind == SEL_OUT_MSG), .a_we(dsp_we),  .a_idx(d_sel.idx), .a_wdata(dsp_wdata),
        .b_sel(h_sel.kind == SEL_OUT_MSG), .b_we(host_we), .b_idx(h_sel.idx), .b_wdata(host_wdata),
        .a_rdata(d_out_msg), .b_rdata(h_out_msg)
      );
    end else begin : g_nomsg
      assign d_in_msg  = '0;
      assign h_in_msg  = '0;
      assign d_out_msg = '0;
      assign h_out_msg = '0;
    end
  endgenerate

  function automatic logic [DATA_W-1:0] read_mux(input sel_t s,
                                                 input logic [DATA_W-1:0] in_msg,
                                                 input logic [DATA_W-1:0] out_msg);
    unique case (s.kind)
      SEL_IN_CMD:  read_mux = DATA_W'(in_cmd);
      SEL_OUT_CMD: read_mux = DATA_W'(out_cmd);
      SEL_IN_MSG:  read_mux = in_msg;
      SEL_OUT_MSG: read_mux = out_msg;
      default:     read_mux = '0;
    endcase
  endfunction

  always_comb begin
    dsp_rdata  = read_mux(d_sel, d_in_msg, d_out_msg);
    host_rdata = read_mux(h_sel, h_in_msg, h_out_msg);
  end

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (d_sel.kind == SEL_IN_CMD || d_sel.kind == SEL_OUT_CMD) |-> dsp_rdata[31:CMD_W] == '0);

  a_r9_msg_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dsp_we && !host_we && (d_sel.kind == SEL_IN_MSG || d_sel.kind == SEL_OUT_MSG))
      |=> ($stable(dsp_irq) && $stable(host_irq)));

  a_r5_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (h_sel.kind == SEL_IN_CLR || h_sel.kind == SEL_OUT_CLR) |-> host_rdata == '0);
endmodule

// File: tb/tb_mbx_top.sv
module tb_mbx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  d_addr = '0, h_addr = '0, cd_addr = '0, ch_addr = '0;
  logic        d_we = 1'b0, h_we = 1'b0, cd_we = 1'b0, ch_we = 1'b0;
  logic [31:0] d_wd = '0, h_wd = '0, cd_wd = '0, ch_wd = '0;
  logic [31:0] d_rd, h_rd, cd_rd, ch_rd;
  logic        d_irq, h_irq, cd_irq, ch_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mbx_top #(.ADDR_W(8), .EXTENDED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .dsp_addr(d_addr), .dsp_we(d_we), .dsp_wdata(d_wd), .dsp_rdata(d_rd),
    .host_addr(h_addr), .host_we(h_we), .host_wdata(h_wd), .host_rdata(h_rd),
    .dsp_irq(d_irq), .host_irq(h_irq)
  );

  mbx_top #(.ADDR_W(8), .EXTENDED(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n),
    .dsp_addr(cd_addr), .dsp_we(cd_we), .dsp_wdata(cd_wd), .dsp_rdata(cd_rd),
    .host_addr(ch_addr), .host_we(ch_we), .host_wdata(ch_wd), .host_rdata(ch_rd),
    .dsp_irq(cd_irq), .host_irq(ch_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // side 0 = DSP port, side 1 = host port; cmp selects the compact instance
  task automatic wr(input bit cmp, input bit side, input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    if (!cmp && !side) begin d_addr = a; d_wd = v; d_we = 1'b1; end
    if (!cmp &&  side) begin h_addr = a; h_wd = v; h_we = 1'b1; end
    if ( cmp && !side) begin cd_addr = a; cd_wd = v; cd_we = 1'b1; end
    if ( cmp &&  side) begin ch_addr = a; ch_wd = v; ch_we = 1'b1; end
    @(negedge clk);
    d_we = 1'b0; h_we = 1'b0; cd_we = 1'b0; ch_we = 1'b0;
  endtask

  task automatic wr_both(input logic [7:0] da, input logic [31:0] dv,
                         input logic [7:0] ha, input logic [31:0] hv);
    @(negedge clk);
    d_addr = da; d_wd = dv; d_we = 1'b1;
    h_addr = ha; h_wd = hv; h_we = 1'b1;
    @(negedge clk);
    d_we = 1'b0; h_we = 1'b0;
  endtask

  task automatic rd(input bit cmp, input bit side, input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    if (!cmp && !side) d_addr = a;
    if (!cmp &&  side) h_addr = a;
    if ( cmp && !side) cd_addr = a;
    if ( cmp &&  side) ch_addr = a;
    #1;
    v = !cmp ? (!side ? d_rd : h_rd) : (!side ? cd_rd : ch_rd);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R11 dsp_irq after reset", {31'b0, d_irq}, 32'd0);
    check("R11 host_irq after reset", {31'b0, h_irq}, 32'd0);
    rd(0, 0, 8'h00, v); check("R11 in_cmd reset", v, 32'd0);
    rd(0, 1, 8'h1C, v); check("R11 out_cmd reset", v, 32'd0);
    rd(0, 0, 8'h10, v); check("R11 in_msg2 reset", v, 32'd0);
    rd(0, 1, 8'h34, v); check("R11 out_msg4 reset", v, 32'd0);
  endtask

  task automatic t_raise();
    logic [31:0] v;
    wr(0, 1, 8'h00, 32'h1);
    check("R2 dsp_irq raised", {31'b0, d_irq}, 32'd1);
    check("R2 host_irq stays low", {31'b0, h_irq}, 32'd0);
    rd(0, 0, 8'h00, v); check("R4 dsp sees in_cmd", v, 32'h1);
    wr(0, 0, 8'h1C, 32'h3);
    check("R2 host_irq raised", {31'b0, h_irq}, 32'd1);
    rd(0, 1, 8'h1C, v); check("R4 host sees out_cmd", v, 32'h3);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    wr(0, 1, 8'h00, 32'hFFFF_FFE4);
    rd(0, 0, 8'h00, v); check("R1 upper bits dropped", v, 32'h4);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(0, 1, 8'h00, 32'h15);
    wr(0, 0, 8'h04, 32'h05);
    rd(0, 0, 8'h00, v); check("R3 partial clear", v, 32'h10);
    check("R2 irq held with bit left", {31'b0, d_irq}, 32'd1);
    rd(0, 1, 8'h04, v); check("R5 in_clr reads zero", v, 32'd0);
    rd(0, 0, 8'h20, v); check("R5 out_clr reads zero", v, 32'd0);
    wr(0, 0, 8'h04, 32'h10);
    check("R2 dsp_irq drops after ack", {31'b0, d_irq}, 32'd0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(0, 1, 8'h1C, 32'h2);
    rd(0, 0, 8'h1C, v); check("R4 direct store clears bit", v, 32'h2);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    wr_both(8'h20, 32'h0F, 8'h1C, 32'h09);
    rd(0, 0, 8'h1C, v); check("R6 set beats clear", v, 32'h09);
    wr(0, 0, 8'h20, 32'h1F);
    check("R2 host_irq drops after ack", {31'b0, h_irq}, 32'd0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr_both(8'h00, 32'h06, 8'h00, 32'h11);
    rd(0, 1, 8'h00, v); check("R7 dsp wins cmd", v, 32'h06);
    wr_both(8'h04, 32'h02, 8'h04, 32'h04);
    rd(0, 0, 8'h00, v); check("R7 clears combine", v, 32'h00);
    wr_both(8'h08, 32'hAAAA_0001, 8'h08, 32'hBBBB_0002);
    rd(0, 1, 8'h08, v); check("R7 dsp wins msg", v, 32'hAAAA_0001);
  endtask

  task automatic t_msg();
    logic [31:0] v;
    for (int i = 0; i < 5; i++)
      wr(0, 1, 8'(8'h08 + 4 * i), 32'h1000_0000 + 32'(i));
    for (int i = 0; i < 5; i++)
      wr(0, 0, 8'(8'h24 + 4 * i), 32'h2000_0000 + 32'(i));
    for (int i = 0; i < 5; i++) begin
      rd(0, 0, 8'(8'h08 + 4 * i), v); check("R8 R9 in_msg by offset", v, 32'h1000_0000 + 32'(i));
    end
    for (int i = 0; i < 5; i++) begin
      rd(0, 1, 8'(8'h24 + 4 * i), v); check("R8 R9 out_msg by offset", v, 32'h2000_0000 + 32'(i));
    end
    check("R9 dsp_irq unaffected", {31'b0, d_irq}, 32'd0);
    check("R9 host_irq unaffected", {31'b0, h_irq}, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(0, 1, 8'h38, 32'hFFFF_FFFF);
    rd(0, 0, 8'h38, v); check("R11 unmapped reads zero", v, 32'd0);
    wr(0, 1, 8'h01, 32'h1F);
    rd(0, 0, 8'h00, v); check("R11 misaligned write ignored", v, 32'd0);
    check("R11 misaligned no irq", {31'b0, d_irq}, 32'd0);
    rd(0, 0, 8'h09, v); check("R11 misaligned reads zero", v, 32'd0);
  endtask

  task automatic t_compact();
    logic [31:0] v;
    wr(1, 0, 8'h04, 32'h3);
    check("R10 compact host_irq", {31'b0, ch_irq}, 32'd1);
    rd(1, 1, 8'h04, v); check("R10 compact out_cmd", v, 32'h3);
    wr(1, 1, 8'h0C, 32'h1);
    rd(1, 0, 8'h04, v); check("R10 compact out_clr", v, 32'h2);
    wr(1, 1, 8'h00, 32'h1);
    check("R10 compact dsp_irq", {31'b0, cd_irq}, 32'd1);
    wr(1, 0, 8'h08, 32'h1);
    rd(1, 1, 8'h00, v); check("R10 compact in_clr", v, 32'h0);
    check("R10 compact dsp_irq drops", {31'b0, cd_irq}, 32'd0);
    wr(1, 0, 8'h10, 32'hDEAD_BEEF);
    rd(1, 1, 8'h10, v); check("R10 no message storage", v, 32'd0);
    rd(1, 1, 8'h04, v); check("R10 cmd unchanged by msg write", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raise();
    t_upper();
    t_clear();
    t_direct();
    t_simul();
    t_prio();
    t_msg();
    t_unmapped();
    t_compact();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule